// File: doc/BRIEF.md
# Splittable Performance Counter Bank

This block holds four physical event counters behind a small register port. Each physical counter runs either as one 32-bit count or as two independent 16-bit counts, so the bank presents eight logical counters. The mode is chosen per physical counter by a split bit in the global control register. Each logical counter has its own one-bit event input and counts while the monitor is enabled.

A software write to a counter does not touch the running value. It lands in a holding latch for that physical counter and is marked pending. Pending values move into the live counters when the control register is written with its enable bit set. That write can either turn the monitor on or rewrite the control register while the monitor is already running.

Every counter wrap sets a sticky status bit. Reading the status register returns those bits and clears them. Writing the status register loads an interrupt-enable mask, and the interrupt output is high while any enabled status bit is set. Every register is 32 bits wide and travels in the upper half of a 64-bit bus word.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low. This covers the counters, holding latches, control, status and interrupt mask.
- R2: A write to a counter register (physical address 4+n, or logical address 8+n) only loads the holding latch. A read of a counter address returns the live value, which does not change until a commit.
- R3: Control sits at address 0, with bit 31 as the enable and bits 3..0 as the split bits of physical counters 3..0. A control write with bit 31 set moves every pending latch into its live counter at once. This holds both when it turns the monitor on and when the monitor is already on.
- R4: While the monitor is enabled, a counter increments by one on each clock with its event input high. While disabled, no counter changes except by a commit.
- R5: In 32-bit mode (split bit 0), `event_in[n]` drives physical counter n and `event_in[n+4]` is ignored. Logical addresses 8+n and 12+n both read and write the full 32-bit value.
- R6: In split mode, logical counter n is bits 31..16 and logical counter n+4 is bits 15..0 of physical counter n. The two halves count independently with no carry between them. A logical read returns the half zero-extended.
- R7: In split mode, a logical write replaces only its own half of the latch. The other half is taken from the pending latch if one exists, and from the live counter otherwise.
- R8: A wrap to zero sets a status bit at address 1. A 32-bit counter n sets bit n. In split mode, the upper half of counter n sets bit n and the lower half sets bit n+4. Status bits stay set until read.
- R9: A status read returns the pending bits in bits 7..0 and clears them. A wrap in the same cycle as the read stays set.
- R10: A status write loads the interrupt mask from bits 7..0. `irq` is high while any status bit that is also masked in is set. A zero mask holds `irq` low.
- R11: Read data bits 31..0 are always zero, and write data bits 31..0 have no effect.
- R12: A commit into a physical counter takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data is valid in the next cycle |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data; bits 63..32 are used |
| rdata | output | 64 | Registered read data; bits 63..32 hold the value |
| event_in | input | 8 | One event bit per logical counter |
| irq | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
A counter write made while the monitor is running must stay invisible until the control register is rewritten. A design that committed on the write itself, or only on a rising enable, would show the new value too early or never. The bench drives a commit and an event in the same cycle: a design with the wrong priority ends one count high. It runs a split counter through a low-half wrap, where a carry into the upper half would corrupt the other logical counter. It also merges two half-writes, where taking the base from the live value instead of the pending latch would lose the first half. Finally, it reads the status register in the same cycle as a wrap: a design where the clear wins would drop that event.

// File: rtl/perf_ctr_pkg.sv
// Package: shared constants for the splittable counter bank.
// Assumes four physical counters, so the address map below fits in four bits.
package perf_ctr_pkg;
    localparam int DEF_NUM_PHYS = 4;
    localparam int DEF_CNT_W    = 32;
    localparam int DEF_ADDR_W   = 4;
    localparam int DEF_BUS_W    = 64;

    localparam logic [DEF_ADDR_W-1:0] ADDR_CTRL = 4'd0;
    localparam logic [DEF_ADDR_W-1:0] ADDR_STAT = 4'd1;
    localparam logic [DEF_ADDR_W-1:0] ADDR_PHYS = 4'd4;
    localparam logic [DEF_ADDR_W-1:0] ADDR_LOG  = 4'd8;
endpackage

// File: rtl/perf_ctr_slice.sv
// Module: one physical counter with its holding latch.
// It counts as one full-width value, or as two independent halves when split
// is set. A commit loads a pending latch and has priority over counting.
// Assumes CNT_W is even.
module perf_ctr_slice #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split,
    input  logic             mon_en,
    input  logic             commit,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ev_hi,
    input  logic             ev_lo,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] hold,
    output logic             pend,
    output logic             ovf_hi,
    output logic             ovf_lo
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  cnt_q, hold_q, cnt_nxt;
    logic              pend_q, commit_now, step, inc_hi, inc_lo;
    logic [HALF_W-1:0] hi_q, lo_q;

    assign hi_q       = cnt_q[CNT_W-1:HALF_W];
    assign lo_q       = cnt_q[HALF_W-1:0];
    assign commit_now = commit & pend_q;
    assign step       = mon_en & ~commit_now;

    // Purpose: next count value and the wrap pulses for each half or the whole.
    always_comb begin
        inc_hi = step & ev_hi;
        inc_lo = step & ev_lo & split;
        if (split) begin
            cnt_nxt = {hi_q + HALF_W'(inc_hi), lo_q + HALF_W'(inc_lo)};
            ovf_hi  = inc_hi & (&hi_q);
        end else begin
            cnt_nxt = cnt_q + CNT_W'(inc_hi);
            ovf_hi  = inc_hi & (&cnt_q);
        end
        ovf_lo = inc_lo & (&lo_q);
    end

    // Purpose: live counter, loaded on commit, else stepped by events.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (commit_now) cnt_q <= hold_q;
        else                 cnt_q <= cnt_nxt;
    end

    // Purpose: holding latch and its pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (ld_en) begin
            hold_q <= ld_val;
            pend_q <= 1'b1;
        end else if (commit_now) begin
            pend_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign hold  = hold_q;
    assign pend  = pend_q;
endmodule

// File: rtl/perf_ctr_regs.sv
// Module: global control, sticky status and interrupt mask.
// Any control write with the enable bit set issues the commit strobe.
// A status read clears the status, but a wrap in the same cycle stays set.
module perf_ctr_regs #(
    parameter int NUM_PHYS = 4,
    parameter int NUM_LOG  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                ctrl_en_bit,
    input  logic [NUM_PHYS-1:0] ctrl_split_bits,
    input  logic                stat_wr,
    input  logic                stat_rd,
    input  logic [NUM_LOG-1:0]  mask_bits,
    input  logic [NUM_LOG-1:0]  ovf,
    output logic                mon_en,
    output logic [NUM_PHYS-1:0] split,
    output logic [NUM_LOG-1:0]  status,
    output logic [NUM_LOG-1:0]  mask,
    output logic                commit,
    output logic                irq
);
    logic [NUM_LOG-1:0] status_q, mask_q;
    logic [NUM_PHYS-1:0] split_q;
    logic en_q;

    assign commit = ctrl_wr & ctrl_en_bit;

    // Purpose: control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            split_q <= '0;
        end else if (ctrl_wr) begin
            en_q    <= ctrl_en_bit;
            split_q <= ctrl_split_bits;
        end
    end

    // Purpose: sticky wrap flags, cleared by read, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (stat_rd ? '0 : status_q) | ovf;
    end

    // Purpose: interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (stat_wr) mask_q <= mask_bits;
    end

    assign mon_en = en_q;
    assign split  = split_q;
    assign status = status_q;
    assign mask   = mask_q;
    assign irq    = |(status_q & mask_q);
endmodule

// File: rtl/perf_ctr_bank.sv
// Module: top of the splittable performance counter bank.
// Decodes the register port, merges half-writes into the holding latches,
// and returns registered read data in the upper half of the bus word.
// Map: 0 control, 1 status, 4+n physical n, 8+n logical n.
// Assumes NUM_PHYS = 4 so that this map fits in ADDR_W bits.
module perf_ctr_bank #(
    parameter int NUM_PHYS = perf_ctr_pkg::DEF_NUM_PHYS,
    parameter int CNT_W    = perf_ctr_pkg::DEF_CNT_W,
    parameter int ADDR_W   = perf_ctr_pkg::DEF_ADDR_W,
    parameter int BUS_W    = perf_ctr_pkg::DEF_BUS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BUS_W-1:0]        wdata,
    output logic [BUS_W-1:0]        rdata,
    input  logic [2*NUM_PHYS-1:0]   event_in,
    output logic                    irq
);
    import perf_ctr_pkg::*;

    localparam int NUM_LOG = 2 * NUM_PHYS;
    localparam int HALF_W  = CNT_W / 2;
    localparam int PIDX_W  = $clog2(NUM_PHYS);
    localparam int DATA_W  = BUS_W / 2;
    localparam int EN_BIT  = DATA_W - 1;

    logic [DATA_W-1:0]         wval;
    logic [PIDX_W-1:0]         pidx;
    logic                      is_phys, is_log, log_low;
    logic                      mon_en, commit;
    logic [NUM_PHYS-1:0]       split, pend, ovf_hi, ovf_lo, ld_en;
    logic [NUM_LOG-1:0]        status, mask, ovf_vec;
    logic [CNT_W-1:0]          cnt  [NUM_PHYS];
    logic [CNT_W-1:0]          hold [NUM_PHYS];
    logic [CNT_W-1:0]          ld_val [NUM_PHYS];
    logic [NUM_PHYS*CNT_W-1:0] cnt_flat;
    logic [DATA_W-1:0]         rd_val, rd_q;

    assign wval    = wdata[BUS_W-1:DATA_W];
    assign pidx    = addr[PIDX_W-1:0];
    assign is_phys = (addr[ADDR_W-1:PIDX_W] == ADDR_PHYS[ADDR_W-1:PIDX_W]);
    assign is_log  = addr[ADDR_W-1];
    assign log_low = addr[PIDX_W];

    perf_ctr_regs #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_wr         (wr_en && addr == ADDR_CTRL),
        .ctrl_en_bit     (wval[EN_BIT]),
        .ctrl_split_bits (wval[NUM_PHYS-1:0]),
        .stat_wr         (wr_en && addr == ADDR_STAT),
        .stat_rd         (rd_en && addr == ADDR_STAT),
        .mask_bits       (wval[NUM_LOG-1:0]),
        .ovf             (ovf_vec),
        .mon_en          (mon_en),
        .split           (split),
        .status          (status),
        .mask            (mask),
        .commit          (commit),
        .irq             (irq)
    );

    for (genvar i = 0; i < NUM_PHYS; i++) begin : g_slice
        logic [CNT_W-1:0] base;
        logic             hit;

        assign hit      = (pidx == PIDX_W'(i));
        assign ld_en[i] = wr_en && hit && (is_phys || is_log);
        assign base     = pend[i] ? hold[i] : cnt[i];

        // Purpose: latch load value, merging one half in split mode.
        always_comb begin
            if (is_log && split[i]) begin
                if (log_low) ld_val[i] = {base[CNT_W-1:HALF_W], wval[HALF_W-1:0]};
                else         ld_val[i] = {wval[HALF_W-1:0], base[HALF_W-1:0]};
            end else begin
                ld_val[i] = wval[CNT_W-1:0];
            end
        end

        perf_ctr_slice #(.CNT_W(CNT_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .split  (split[i]),
            .mon_en (mon_en),
            .commit (commit),
            .ld_en  (ld_en[i]),
            .ld_val (ld_val[i]),
            .ev_hi  (event_in[i]),
            .ev_lo  (event_in[i+NUM_PHYS]),
            .count  (cnt[i]),
            .hold   (hold[i]),
            .pend   (pend[i]),
            .ovf_hi (ovf_hi[i]),
            .ovf_lo (ovf_lo[i])
        );

        assign ovf_vec[i]          = ovf_hi[i];
        assign ovf_vec[i+NUM_PHYS] = ovf_lo[i];
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
    end

    // Purpose: select the value for the addressed register.
    always_comb begin
        rd_val = '0;
        if (addr == ADDR_CTRL) begin
            rd_val[EN_BIT]         = mon_en;
            rd_val[NUM_PHYS-1:0]   = split;
        end else if (addr == ADDR_STAT) begin
            rd_val[NUM_LOG-1:0]    = status;
        end else if (is_phys) begin
            rd_val[CNT_W-1:0]      = cnt[pidx];
        end else if (is_log) begin
            if (!split[pidx])  rd_val[CNT_W-1:0]  = cnt[pidx];
            else if (log_low)  rd_val[HALF_W-1:0] = cnt[pidx][HALF_W-1:0];
            else               rd_val[HALF_W-1:0] = cnt[pidx][CNT_W-1:HALF_W];
        end
    end

    // Purpose: registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_val;
    end

    assign rdata = {rd_q, {DATA_W{1'b0}}};
endmodule

// File: rtl/perf_ctr_bank_chk.sv
// Module: property checker for perf_ctr_bank, bound to the top below.
// Assumes the default address map from perf_ctr_pkg.
module perf_ctr_bank_chk #(
    parameter int NUM_PHYS = 4,
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 4,
    parameter int BUS_W    = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [BUS_W-1:0]          rdata,
    input logic                      irq,
    input logic                      mon_en,
    input logic [2*NUM_PHYS-1:0]     status,
    input logic [2*NUM_PHYS-1:0]     ovf_vec,
    input logic [NUM_PHYS*CNT_W-1:0] cnt_flat
);
    import perf_ctr_pkg::*;

    // R4 and R2: with the monitor off and no control write, nothing moves.
    p_frozen_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !(wr_en && addr == ADDR_CTRL)) |=> $stable(cnt_flat));

    // R11: the lower half of the read word is always zero.
    p_low_half_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W/2-1:0] == '0);

    // R9: a status read with no wrap in the same cycle leaves status clear.
    p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_STAT && ovf_vec == '0) |=> (status == '0));

    // R8: status bits are sticky when not read.
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == ADDR_STAT) |=> ((status & $past(status)) == $past(status)));

    // R8: a wrap pulse always lands in status.
    p_wrap_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) |=> ((status & $past(ovf_vec)) == $past(ovf_vec)));

    // R10: the interrupt never rises without a pending status bit.
    p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(
    .NUM_PHYS (NUM_PHYS),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .BUS_W    (BUS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq      (irq),
    .mon_en   (mon_en),
    .status   (status),
    .ovf_vec  (ovf_vec),
    .cnt_flat (cnt_flat)
);

// File: tb/perf_ctr_bank_tb.sv
`timescale 1ns/1ps
// Directed bench for perf_ctr_bank: one task per scenario.
module perf_ctr_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [7:0]  event_in = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [31:0] EN = 32'h8000_0000;

    always #5 clk = ~clk;

    perf_ctr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .event_in(event_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = {d, 32'hDEAD_BEEF};
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata[63:32];
        chk("R11 low half", rdata[31:0], 32'h0);
    endtask

    task automatic pulse_ev(input logic [7:0] m, input int n);
        @(negedge clk);
        event_in = m;
        repeat (n) @(negedge clk);
        event_in = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_rd(4'd0, v);  chk("R1 ctrl", v, 0);
        bus_rd(4'd1, v);  chk("R1 status", v, 0);
        bus_rd(4'd4, v);  chk("R1 phys0", v, 0);
        bus_rd(4'd12, v); chk("R1 log4", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_latch;
        logic [31:0] v;
        bus_wr(4'd4, 32'h100);
        bus_rd(4'd4, v);  chk("R2 latch only", v, 0);
        bus_wr(4'd0, EN);
        bus_rd(4'd4, v);  chk("R3 enable commits", v, 32'h100);
        bus_rd(4'd0, v);  chk("R3 ctrl readback", v, EN);
    endtask

    task automatic t_count32;
        logic [31:0] v;
        pulse_ev(8'h11, 5);
        bus_rd(4'd4, v);  chk("R5 ev4 ignored, R4 count", v, 32'h105);
        bus_rd(4'd8, v);  chk("R5 log0 full", v, 32'h105);
        bus_rd(4'd12, v); chk("R5 log4 full", v, 32'h105);
        bus_wr(4'd0, 32'h0);
        pulse_ev(8'h01, 3);
        bus_rd(4'd4, v);  chk("R4 disabled holds", v, 32'h105);
    endtask

    task automatic t_rewrite;
        logic [31:0] v;
        bus_wr(4'd5, 32'h55);
        bus_wr(4'd0, EN);
        bus_rd(4'd5, v);  chk("R3 commit phys1", v, 32'h55);
        bus_wr(4'd5, 32'h77);
        bus_rd(4'd5, v);  chk("R2 latch while enabled", v, 32'h55);
        bus_wr(4'd0, EN);
        bus_rd(4'd5, v);  chk("R3 rewrite commits", v, 32'h77);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        bus_wr(4'd6, 32'h10);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wdata = {EN, 32'h0}; event_in = 8'h04;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; event_in = '0;
        bus_rd(4'd6, v);  chk("R12 commit beats increment", v, 32'h10);
        pulse_ev(8'h04, 2);
        bus_rd(4'd6, v);  chk("R4 counting resumes", v, 32'h12);
    endtask

    task automatic t_split;
        logic [31:0] v;
        bus_wr(4'd7, 32'h1234_FFFE);
        bus_wr(4'd0, EN | 32'h8);
        pulse_ev(8'h80, 3);
        pulse_ev(8'h08, 2);
        bus_rd(4'd7, v);  chk("R6 no carry", v, 32'h1236_0001);
        bus_rd(4'd11, v); chk("R6 log3 upper", v, 32'h1236);
        bus_rd(4'd15, v); chk("R6 log7 lower", v, 32'h0001);
        bus_rd(4'd1, v);  chk("R8 low half wrap bit7", v, 32'h80);
        bus_rd(4'd1, v);  chk("R9 read cleared", v, 0);
    endtask

    task automatic t_merge;
        logic [31:0] v;
        bus_wr(4'd15, 32'hAAAA);
        bus_wr(4'd11, 32'h5555);
        bus_rd(4'd7, v);  chk("R2 halves latched", v, 32'h1236_0001);
        bus_wr(4'd0, EN | 32'h8);
        bus_rd(4'd7, v);  chk("R7 merged halves", v, 32'h5555_AAAA);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        bus_wr(4'd1, 32'h01);
        bus_wr(4'd4, 32'hFFFF_FFFE);
        bus_wr(4'd0, EN | 32'h8);
        chk("R10 irq low before wrap", {31'b0, irq}, 0);
        pulse_ev(8'h01, 2);
        bus_rd(4'd4, v);  chk("R4 32-bit wrap", v, 0);
        chk("R10 irq high", {31'b0, irq}, 1);
        bus_rd(4'd1, v);  chk("R8 bit0 only", v, 32'h01);
        chk("R10 irq drops after read", {31'b0, irq}, 0);
        bus_wr(4'd1, 32'h0);
        bus_wr(4'd4, 32'hFFFF_FFFF);
        bus_wr(4'd0, EN | 32'h8);
        pulse_ev(8'h01, 1);
        chk("R10 zero mask keeps irq low", {31'b0, irq}, 0);
        bus_rd(4'd1, v);  chk("R8 masked wrap still flagged", v, 32'h01);
    endtask

    task automatic t_setwins;
        logic [31:0] v;
        bus_wr(4'd5, 32'hFFFF_FFFF);
        bus_wr(4'd0, EN | 32'h8);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'd1; event_in = 8'h02;
        @(negedge clk);
        rd_en = 1'b0; event_in = '0;
        chk("R9 read returns old status", rdata[63:32], 0);
        bus_rd(4'd1, v);  chk("R9 set beats clear", v, 32'h02);
        bus_rd(4'd5, v);  chk("R4 phys1 wrapped", v, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_count32();
        t_rewrite();
        t_priority();
        t_split();
        t_merge();
        t_irq();
        t_setwins();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule